// File: doc/BRIEF.md
# Column-Compressed 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their 8-bit product. Sixteen single-bit partial products come from an AND array. A column-compression network of half adders and full adders shrinks the tallest column, which holds four bits, in two steps: first to a height of three, then to two. Each full adder is built from an equivalence term that drives both the sum and a carry multiplexer. The result is two 6-bit rows. A 6-bit parallel-prefix adder of the Brent-Kung kind sums the rows and gives product bits 1 to 7, with its carry-out as the top bit. Product bit 0 is the lowest partial product and does not pass through the adder.

Operands enter on a valid/ready stream and the product leaves on another one. The parameter `REG_OUT` selects the variant. With `REG_OUT = 0` the block is pure logic: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the product belongs to the operands on the same cycle. With `REG_OUT = 1` a single output stage holds the product. It accepts a new pair when it is empty or when its content leaves on the same edge. While `out_ready` is low, a valid product and its flag stay as they are. The stage clears on a synchronous active-high reset.

Top module: `colcomp_mult`

## Requirements
- R1: With any of the 256 operand pairs, the product equals the unsigned product of `in_a` and `in_b`, read as integers from 0 to 15.
- R2: Product bit 0 always equals `in_a[0] AND in_b[0]`.
- R3: Operands 12 and 12 give 144 (binary 1001_0000), so only bits 4 and 7 are set.
- R4: Operands 15 and 15 give 225, which sets bit 7 through the prefix carry-out. A zero operand gives a product of 0.
- R5: With `REG_OUT = 0`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle.
- R6: With `REG_OUT = 1`, a pair accepted on an edge (`in_valid` and `in_ready` both high) appears on `out_prod`, with `out_valid` high, right after that edge.
- R7: With `REG_OUT = 1`, while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` stays unchanged on the next edge.
- R8: With `REG_OUT = 1`, `in_ready` is high exactly when the stage is empty or `out_ready` is high.
- R9: With `REG_OUT = 1`, a cycle with `rst` high leaves `out_valid` low after the edge.
- R10: With `REG_OUT = 1`, when `out_valid` and `out_ready` are high and no new pair is accepted, `out_valid` falls after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block takes the operand pair on this edge |
| in_a | input | 4 | Multiplicand, unsigned |
| in_b | input | 4 | Multiplier, unsigned |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 8 | Unsigned product |

## Verification
The bench builds the block twice from the same stimulus: once with `REG_OUT = 1` as `dut` and once with `REG_OUT = 0`. The logic-only instance checks each of the 256 operand pairs in the cycle it is applied. The registered instance is driven with a pseudo-random `out_ready` pattern, so stalls, back-to-back transfers, drain cycles and a reset that arrives while a product is held all happen, and a behavioural queue model predicts its flag and product on every clock.

// File: rtl/colcomp_mult_pkg.sv
package colcomp_mult_pkg;
  localparam int OP_W   = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int ROW_W  = PROD_W - 2;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // (2,2) compressor: returns {carry, sum}
  function automatic logic [1:0] half_add(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  // prefix combine of an upper span with the span just below it
  function automatic pg_t span_merge(input pg_t hi, input pg_t lo);
    pg_t r;
    r.p = hi.p & lo.p;
    r.g = hi.g | (hi.p & lo.g);
    return r;
  endfunction

  // carry out of a span given the carry entering it
  function automatic logic carry_fill(input pg_t hi, input logic cin);
    return hi.g | (hi.p & cin);
  endfunction
endpackage

// File: rtl/cc_fa.sv
module cc_fa (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic eq_ab;
  assign eq_ab = ~(a ^ b);
  assign sum   = ~(eq_ab ^ cin);
  assign cout  = eq_ab ? a : cin;
endmodule

// File: rtl/cc_dadda4.sv
module cc_dadda4
  import colcomp_mult_pkg::*;
(
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic             lsb,
  output logic [ROW_W-1:0] row_x,
  output logic [ROW_W-1:0] row_y
);
  // pp[i][j] has weight i+j
  logic [OP_W-1:0][OP_W-1:0] pp;

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    for (genvar j = 0; j < OP_W; j++) begin : g_col
      assign pp[i][j] = a[i] & b[j];
    end
  end

  // step one: height 4 -> 3 (columns 3 and 4)
  logic s1, c1, s2, c2;
  assign {c1, s1} = half_add(pp[3][0], pp[2][1]);
  assign {c2, s2} = half_add(pp[3][1], pp[2][2]);

  // step two: height 3 -> 2 (columns 2 to 5)
  logic s3, c3, s4, c4, s5, c5, s6, c6;
  assign {c3, s3} = half_add(pp[2][0], pp[1][1]);

  cc_fa u_fa_col3 (.a(s1), .b(pp[1][2]), .cin(pp[0][3]), .sum(s4), .cout(c4));
  cc_fa u_fa_col4 (.a(c1), .b(s2),       .cin(pp[1][3]), .sum(s5), .cout(c5));
  cc_fa u_fa_col5 (.a(c2), .b(pp[3][2]), .cin(pp[2][3]), .sum(s6), .cout(c6));

  assign lsb   = pp[0][0];
  assign row_x = {pp[3][3], s6, s5, s4, s3, pp[1][0]};
  assign row_y = {c6, c5, c4, c3, pp[0][2], pp[0][1]};
endmodule

// File: rtl/cc_bk6.sv
module cc_bk6
  import colcomp_mult_pkg::*;
(
  input  logic [ROW_W-1:0] x,
  input  logic [ROW_W-1:0] y,
  output logic [ROW_W-1:0] sum,
  output logic             cout
);
  pg_t [ROW_W-1:0] pg;
  logic [ROW_W-1:0] carry;

  for (genvar i = 0; i < ROW_W; i++) begin : g_pre
    assign pg[i].p = x[i] ^ y[i];
    assign pg[i].g = x[i] & y[i];
  end

  // up-sweep: distance 1, then distance 2
  pg_t sp10, sp32, sp54, sp30;
  assign sp10 = span_merge(pg[1], pg[0]);
  assign sp32 = span_merge(pg[3], pg[2]);
  assign sp54 = span_merge(pg[5], pg[4]);
  assign sp30 = span_merge(sp32, sp10);

  logic unused_p30;
  assign unused_p30 = sp30.p;

  // carries out of each position; no carry enters position 0
  assign carry[0] = pg[0].g;
  assign carry[1] = sp10.g;
  assign carry[3] = sp30.g;
  // down-sweep fill-in
  assign carry[2] = carry_fill(pg[2], carry[1]);
  assign carry[4] = carry_fill(pg[4], carry[3]);
  assign carry[5] = carry_fill(sp54, carry[3]);

  assign sum[0] = pg[0].p;
  for (genvar i = 1; i < ROW_W; i++) begin : g_post
    assign sum[i] = pg[i].p ^ carry[i-1];
  end
  assign cout = carry[ROW_W-1];
endmodule

// File: rtl/colcomp_mult.sv
module colcomp_mult
  import colcomp_mult_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_prod
);
  logic             lsb;
  logic [ROW_W-1:0] row_x, row_y, hi_sum;
  logic             hi_cout;
  logic [PROD_W-1:0] prod_c;

  cc_dadda4 u_reduce (
    .a(in_a), .b(in_b), .lsb(lsb), .row_x(row_x), .row_y(row_y)
  );

  cc_bk6 u_final (
    .x(row_x), .y(row_y), .sum(hi_sum), .cout(hi_cout)
  );

  assign prod_c = {hi_cout, hi_sum, lsb};

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [PROD_W-1:0] prod_q;
    logic              take;

    assign in_ready = !vld_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else if (take) begin
        vld_q  <= 1'b1;
        prod_q <= prod_c;
      end else if (out_ready) begin
        vld_q  <= 1'b0;
      end
    end

    assign out_valid = vld_q;
    assign out_prod  = prod_q;
  end else begin : g_comb
    logic unused_clkrst;
    assign unused_clkrst = clk ^ rst;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_prod  = prod_c;
  end
endmodule

// File: rtl/colcomp_mult_chk.sv
module colcomp_mult_chk
  import colcomp_mult_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_a,
  input logic [OP_W-1:0]   in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PROD_W-1:0] out_prod
);
  if (REG_OUT) begin : g_reg
    a_r6_take_appears: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=>
        (out_valid && out_prod == PROD_W'($past(in_a)) * PROD_W'($past(in_b))));

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

    a_r9_reset_empties: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

    a_r10_drain: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

    a_r2_lsb_held: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_prod[0] == ($past(in_a[0]) & $past(in_b[0])) || $past(out_valid));
  end else begin : g_comb
    a_r1_product: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_prod == PROD_W'(in_a) * PROD_W'(in_b));

    a_r2_lsb: assert property (@(posedge clk) disable iff (rst)
      out_prod[0] == (in_a[0] & in_b[0]));

    a_r4_top_carry: assert property (@(posedge clk) disable iff (rst)
      (in_a == '1 && in_b == '1) |-> out_prod[PROD_W-1]);
  end
endmodule

bind colcomp_mult colcomp_mult_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_prod(out_prod)
);

// File: tb/tb_colcomp_mult.sv
module tb_colcomp_mult;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_a = '0;
  logic [3:0] in_b = '0;
  logic       out_ready = 1'b0;

  logic       r_in_ready, r_out_valid;
  logic [7:0] r_out_prod;
  logic       c_in_ready, c_out_valid;
  logic [7:0] c_out_prod;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural model of the registered variant
  bit       m_v = 1'b0;
  int       m_q = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  colcomp_mult #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(r_out_valid), .out_ready(out_ready),
    .out_prod(r_out_prod)
  );

  colcomp_mult #(.REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_prod(c_out_prod)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic step(input bit v, input int a, input int b, input bit rdy, output bit took);
    bit stalled;
    int exp_p;
    @(negedge clk);
    in_valid  = v;
    in_a      = 4'(a);
    in_b      = 4'(b);
    out_ready = rdy;
    #1;
    exp_p = a * b;
    // logic-only variant
    chk(c_out_valid == v, "R5", c_out_valid, v);
    chk(c_in_ready == rdy, "R5", c_in_ready, rdy);
    if (v) begin
      chk(c_out_prod == 8'(exp_p), "R1", c_out_prod, exp_p);
      chk(c_out_prod[0] == 1'(a & b & 1), "R2", c_out_prod[0], a & b & 1);
      if (a == 12 && b == 12)
        chk(c_out_prod == 8'b1001_0000, "R3", c_out_prod, 144);
      if (a == 15 && b == 15)
        chk(c_out_prod[7] == 1'b1 && c_out_prod == 8'd225, "R4", c_out_prod, 225);
      if (a == 0 || b == 0)
        chk(c_out_prod == 8'd0, "R4", c_out_prod, 0);
    end
    // registered variant
    chk(r_in_ready == (!m_v || rdy), "R8", r_in_ready, (!m_v || rdy));
    chk(r_out_valid == m_v, "R6", r_out_valid, m_v);
    if (m_v) chk(r_out_prod == 8'(m_q), "R6", r_out_prod, m_q);
    stalled = m_v && !rdy;
    took = v && (!m_v || rdy);
    @(posedge clk);
    if (took) begin
      m_v = 1'b1;
      m_q = exp_p;
    end else if (rdy) begin
      m_v = 1'b0;
    end
    #1;
    if (stalled) begin
      chk(r_out_valid == 1'b1, "R7", r_out_valid, 1);
      chk(r_out_prod == 8'(m_q), "R7", r_out_prod, m_q);
    end else if (!took && rdy) begin
      chk(r_out_valid == 1'b0, "R10", r_out_valid, 0);
    end
  endtask

  initial begin
    bit took;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(r_out_valid == 1'b0, "R9", r_out_valid, 0);
    chk(r_in_ready == 1'b1, "R8", r_in_ready, 1);

    for (int i = 0; i < 256; i++) begin
      took = 1'b0;
      while (!took) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(1'b1, i / 16, i % 16, lfsr[0] | lfsr[2], took);
      end
      if (i % 32 == 31) begin
        step(1'b0, 0, 0, 1'b1, took);
        step(1'b0, 0, 0, 1'b1, took);
      end
    end

    // explicit corners with the consumer always ready
    step(1'b1, 12, 12, 1'b1, took);
    step(1'b1, 15, 15, 1'b1, took);
    step(1'b0, 0, 0, 1'b1, took);

    // reset while a product is held under stall
    step(1'b1, 5, 5, 1'b0, took);
    step(1'b0, 0, 0, 1'b0, took);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    m_v = 1'b0;
    #1;
    chk(r_out_valid == 1'b0, "R9", r_out_valid, 0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule